// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines from peripherals and folds them into one interrupt signal toward the processor. The lines have a fixed priority, and line 0 is the most urgent. When the processor answers with an acknowledge pulse, the controller places the winning line's vector on its vector bus in that same cycle. The vector is a fixed base plus the line index. The controller also records the winning line as in service.

A line stays in service until the processor signals end of service. End of service always retires the most urgent level that is in service. Requests at or below the most urgent in-service level are latched as pending and held back. A request that is more urgent than every in-service level raises the interrupt at once, so service routines can nest.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the interrupt output is low, the vector bus is zero even with acknowledge high, and no request is pending or in service.
- R2: A request line that is high at a clock edge is latched as pending. The interrupt output rises in the following cycle and stays high after the line drops, until the request is acknowledged.
- R3: Line 0 has the highest priority. When several eligible requests are pending, acknowledge selects the lowest-numbered one.
- R4: While acknowledge is high and the interrupt output is high, the vector bus carries 0x20 plus the selected line index (8-bit bus, 8 lines). In every other cycle the bus is zero.
- R5: An acknowledge that is taken sets the selected line in service and clears its pending state. The interrupt output then drops unless another eligible request is pending.
- R6: A request on a line numbered at or above the most urgent in-service line does not raise the interrupt output. It stays pending and is presented once every in-service line at or above its priority is cleared.
- R7: A request on a line more urgent than every in-service line raises the interrupt output during service and can be acknowledged, which nests service.
- R8: End of service clears only the lowest-numbered in-service line.
- R9: An acknowledge while the interrupt output is low gives a zero vector and changes no pending or in-service state.
- R10: Requests are level-sensitive. A line still held high after its acknowledge is latched again, and it raises the interrupt in the cycle after its end of service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Level-sensitive request lines, bit 0 most urgent |
| ack_i | input | 1 | Processor interrupt acknowledge |
| eoi_i | input | 1 | End-of-service pulse from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector of the selected line during acknowledge, zero otherwise |

## Verification
If a pending bit is lost or stuck, the interrupt output is wrong in the cycle after the request is sampled. A stuck in-service bit shows up when a lower-priority line never raises the interrupt after end of service. If end of service clears the wrong level, a line that should stay blocked raises the interrupt in the next cycle. A fault in priority selection or vector arithmetic is visible on the vector bus in the same cycle as acknowledge. The bench therefore samples both outputs in every cycle of each sequence, not only at the end of it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DEF_N_SRC    = 8;
  localparam int unsigned DEF_VEC_W    = 8;
  localparam int unsigned DEF_VEC_BASE = 32'h20;
endpackage

// File: rtl/pic_first_set.sv
// Lowest-index set bit: one-hot, index and any.
module pic_first_set #(
  parameter int unsigned W     = 8,
  localparam int unsigned IW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  in_i,
  output logic [W-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign seen[i+1] = seen[i] | in_i[i];
    assign oh_o[i]   = in_i[i] & ~seen[i];
  end

  assign any_o = seen[W];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (oh_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/pic_level_mask.sv
// allow_o[i] high when no line at index <= i is in service.
module pic_level_mask #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] isr_i,
  output logic [N-1:0] allow_o
);
  logic [N:0] busy;
  assign busy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign busy[i+1]  = busy[i] | isr_i[i];
    assign allow_o[i] = ~busy[i+1];
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int unsigned N_SRC    = pic_pkg::DEF_N_SRC,
  parameter int unsigned VEC_W    = pic_pkg::DEF_VEC_W,
  parameter int unsigned VEC_BASE = pic_pkg::DEF_VEC_BASE,
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] pend_q, isr_q, pend_d, isr_d;
  logic [N_SRC-1:0] allow, elig, win_oh, ack_oh;
  logic [N_SRC-1:0] top_isr_oh, eoi_clr;
  logic [IDX_W-1:0] win_idx, top_isr_idx;
  logic             any_isr, take;

  pic_level_mask #(.N(N_SRC)) u_mask (
    .isr_i   (isr_q),
    .allow_o (allow)
  );

  assign elig = pend_q & allow;

  pic_first_set #(.W(N_SRC)) u_win (
    .in_i  (elig),
    .oh_o  (win_oh),
    .idx_o (win_idx),
    .any_o (irq_o)
  );

  pic_first_set #(.W(N_SRC)) u_top_isr (
    .in_i  (isr_q),
    .oh_o  (top_isr_oh),
    .idx_o (top_isr_idx),
    .any_o (any_isr)
  );

  assign take    = ack_i & irq_o;
  assign ack_oh  = take  ? win_oh     : '0;
  assign eoi_clr = eoi_i ? top_isr_oh : '0;

  assign vec_o = take ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;

  assign pend_d = (pend_q | req_i) & ~ack_oh;
  assign isr_d  = (isr_q & ~eoi_clr) | ack_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  // R5
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !eoi_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  // R5
  ack_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ((pend_q & $past(win_oh)) == '0));

  // R7
  nest_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !eoi_i) |=> (top_isr_oh == $past(win_oh)));

  // R8
  eoi_one_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !take && any_isr) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R4
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> (int'(vec_o) >= int'(VEC_BASE) && int'(vec_o) < int'(VEC_BASE) + int'(N_SRC)));

  // R9
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi_i) |=> $stable(isr_q));
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int NR = 37;
  // {req[7:0], ack, eoi, exp_irq, exp_vec[7:0], tag[7:0]}
  localparam logic [26:0] TBL [0:NR-1] = '{
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd1},  // R1 idle
    {8'h10,1'b0,1'b0,1'b0,8'h00,8'd2},  // R2 not yet latched
    {8'h10,1'b0,1'b0,1'b1,8'h00,8'd2},  // R2 irq up
    {8'h10,1'b1,1'b0,1'b1,8'h24,8'd4},  // R4 vector line 4
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd5},  // R5 irq dropped
    {8'h40,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 lower line 6
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 blocked
    {8'h10,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 equal line 4
    {8'h04,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 still blocked
    {8'h00,1'b0,1'b0,1'b1,8'h00,8'd7},  // R7 line 2 nests
    {8'h00,1'b1,1'b0,1'b1,8'h22,8'd7},  // R7 ack line 2
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd7},  // R7 isr {2,4}
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8 clear 2
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd8},  // R8 line 4 still blocks
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8 clear 4
    {8'h00,1'b0,1'b0,1'b1,8'h00,8'd6},  // R6 pending presented
    {8'h00,1'b1,1'b0,1'b1,8'h24,8'd3},  // R3 4 beats 6
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 6 blocked by 4
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8
    {8'h00,1'b1,1'b0,1'b1,8'h26,8'd4},  // R4 line 6
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8
    {8'h01,1'b0,1'b0,1'b0,8'h00,8'd2},  // R2
    {8'h00,1'b1,1'b0,1'b1,8'h20,8'd2},  // R2 held after drop
    {8'h80,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 line 7 under 0
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd6},  // R6
    {8'h00,1'b0,1'b0,1'b1,8'h00,8'd6},  // R6 released
    {8'h00,1'b1,1'b0,1'b1,8'h27,8'd4},  // R4 line 7
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8
    {8'h00,1'b1,1'b0,1'b0,8'h00,8'd9},  // R9 idle ack
    {8'h03,1'b0,1'b0,1'b0,8'h00,8'd3},  // R3
    {8'h00,1'b0,1'b0,1'b1,8'h00,8'd3},  // R3
    {8'h00,1'b1,1'b0,1'b1,8'h20,8'd3},  // R3 0 beats 1
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd6},  // R6 1 under 0
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8
    {8'h00,1'b1,1'b0,1'b1,8'h21,8'd3},  // R3 then 1
    {8'h00,1'b0,1'b1,1'b0,8'h00,8'd8},  // R8
    {8'h00,1'b0,1'b0,1'b0,8'h00,8'd9}   // R9 nothing left
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0;
  logic       ack_i = 1'b0, eoi_i = 1'b0;
  logic       irq_o;
  logic [7:0] vec_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  prio_vec_intc u_prio_vec_intc (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic check(input string tag, input logic eirq, input logic [7:0] evec);
    n_chk++;
    if (irq_o !== eirq || vec_o !== evec) begin
      n_fail++;
      $display("FAIL %s: irq=%b vec=%h expected irq=%b vec=%h", tag, irq_o, vec_o, eirq, evec);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic a, input logic e);
    @(negedge clk_i);
    req_i = r; ack_i = a; eoi_i = e;
    #5;
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    ack_i = 1'b1;
    #15;
    check("R1 in reset", 1'b0, 8'h00);
    @(negedge clk_i);
    ack_i = 1'b0;
    rst_ni = 1'b1;
    step(8'h00, 1'b1, 1'b0);
    check("R1 after reset", 1'b0, 8'h00);

    for (int i = 0; i < NR; i++) begin
      step(TBL[i][26:19], TBL[i][18], TBL[i][17]);
      check($sformatf("row %0d R%0d", i, TBL[i][7:0]), TBL[i][16], TBL[i][15:8]);
    end

    // R1 reset drops latched pending
    step(8'h20, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    check("R2 pending line 5", 1'b1, 8'h00);
    rst_ni = 1'b0;
    #2;
    check("R1 reset clears pending", 1'b0, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 held level request re-presents after end of service
    step(8'h08, 1'b0, 1'b0);
    step(8'h08, 1'b0, 1'b0);
    check("R10 irq up", 1'b1, 8'h00);
    step(8'h08, 1'b1, 1'b0);
    check("R10 ack line 3", 1'b1, 8'h23);
    step(8'h08, 1'b0, 1'b0);
    check("R10 blocked by own service", 1'b0, 8'h00);
    step(8'h08, 1'b0, 1'b1);
    check("R10 eoi cycle", 1'b0, 8'h00);
    step(8'h00, 1'b0, 1'b0);
    check("R10 re-raised", 1'b1, 8'h00);
    step(8'h00, 1'b1, 1'b0);
    check("R10 second ack", 1'b1, 8'h23);
    step(8'h00, 1'b0, 1'b1);
    step(8'h00, 1'b0, 1'b0);
    check("R10 quiet", 1'b0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule